// File: doc/BRIEF.md
# Shared-Exponent RGB Decoder

This block unpacks a 32-bit packed colour word into four IEEE 754 single-precision values. The word carries three 9-bit unsigned mantissas, one each for red, green and blue, and a single 5-bit exponent that scales all three. The mantissas have no hidden leading one, and the format has no sign, infinity or NaN encodings. Each channel is therefore an unsigned integer turned into a float and then scaled by a power of two that is shared across the channels. The fourth output, alpha, is always 1.0.

Words arrive on a valid/ready input. A word is accepted on any clock edge where both `in_valid` and `in_ready` are high. The four floats appear on registered outputs one clock edge later, together with `out_valid`. No backpressure is applied from the output side, so `in_ready` stays high except while the block is in reset. The reset is asserted asynchronously and released in step with the clock.

Top module: `shexp_decoder`

## Requirements
- R1: The input fields sit at fixed positions: red mantissa in bits 8:0, green mantissa in bits 17:9, blue mantissa in bits 26:18, and the unsigned shared exponent e in bits 31:27.
- R2: A nonzero mantissa m produces the exact single-precision value m × 2^(e − 24). That is sign 0, biased exponent 103 + e + p where p is the position of the most significant set bit of m, and the bits of m below that position left-aligned in the 23-bit fraction.
- R3: A zero mantissa produces 0x00000000 for any value of the exponent.
- R4: Whenever `out_valid` is high, `out_alpha` equals 0x3F800000 (1.0).
- R5: An accepted word gives `out_valid` high after exactly one clock edge, with all channel results in that same cycle. A cycle with no accepted word gives `out_valid` low after the next edge. Back-to-back words are decoded at one word per cycle.
- R6: While `rst_n` is low, `out_valid` and `in_ready` are low, with `out_valid` cleared without waiting for a clock edge. After `rst_n` rises, `in_ready` goes high on the second rising clock edge. A word presented before then produces no output.
- R7: In a cycle with no accepted word, the colour and alpha outputs keep their previous values, whatever is on `in_word`.
- R8: Every nonzero result is a normal number. The smallest is 0x33800000 (2^−24, for m = 1, e = 0) and the largest is 0x477F8000 (511 × 2^7, for m = 511, e = 31).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 32 | Packed word: three mantissas and the shared exponent |
| out_valid | output | 1 | Output floats hold a decoded word |
| out_red | output | 32 | Red channel as single-precision float |
| out_green | output | 32 | Green channel as single-precision float |
| out_blue | output | 32 | Blue channel as single-precision float |
| out_alpha | output | 32 | Alpha channel, 1.0 when valid |

## Verification
Every decoded result is due exactly one rising edge after the edge that accepts its word. The bench changes inputs on falling edges and reads outputs on the next falling edge, so each check falls in the cycle the result is due. In a back-to-back stream, each falling edge carries the result of the word driven half a cycle before the previous rising edge. After reset release, `in_ready` is checked as still low after the first rising edge and high after the second. The first word is counted one edge after that.

// File: rtl/shexp_pkg.sv
package shexp_pkg;
  localparam int FP_W      = 32;
  localparam int FP_EXP_W  = 8;
  localparam int FP_FRAC_W = 23;
  localparam int FP_BIAS   = 127;
  localparam logic [FP_W-1:0] FP_ONE = 32'h3F80_0000;

  typedef logic [FP_W-1:0] fp32_t;
endpackage

// File: rtl/shexp_rst_sync.sv
module shexp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/shexp_lead_one.sv
module shexp_lead_one #(
  parameter int W = 9,
  localparam int POS_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [POS_W-1:0] pos,
  output logic             found
);
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos   = POS_W'(i);
        found = 1'b1;
      end
    end
  end

  // the reported bit is set and nothing above it is
  always_comb begin
    if (found) begin
      AST_LEAD_ONE_TOP : assert ((vec >> pos) == W'(1)); // R2
    end
  end
endmodule

// File: rtl/shexp_chan_conv.sv
module shexp_chan_conv
  import shexp_pkg::*;
#(
  parameter int MANT_W   = 9,
  parameter int EXP_W    = 5,
  parameter int EXP_BIAS = 15
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  sh_exp,
  output fp32_t             fp
);
  localparam int POS_W   = (MANT_W > 1) ? $clog2(MANT_W) : 1;
  localparam int EXP_OFS = FP_BIAS - EXP_BIAS - MANT_W;
  localparam int PAD_W   = FP_FRAC_W - MANT_W + 1;

  logic [POS_W-1:0]    lead_pos;
  logic                nonzero;
  logic [POS_W-1:0]    sh_amt;
  logic [MANT_W-1:0]   norm;
  logic [FP_EXP_W-1:0] exp_sum;
  logic [FP_FRAC_W-1:0] frac;

  shexp_lead_one #(.W(MANT_W)) u_lead (
    .vec   (mant),
    .pos   (lead_pos),
    .found (nonzero)
  );

  always_comb begin
    sh_amt  = POS_W'(MANT_W - 1) - lead_pos;
    norm    = mant << sh_amt;
    frac    = {norm[MANT_W-2:0], {PAD_W{1'b0}}};
    exp_sum = FP_EXP_W'(EXP_OFS) + FP_EXP_W'(sh_exp) + FP_EXP_W'(lead_pos);
    fp      = nonzero ? {1'b0, exp_sum, frac} : '0;
  end

  // normalisation must bring the leading one to the top bit
  always_comb begin
    if (nonzero) begin
      AST_NORM_MSB_SET : assert (norm[MANT_W-1]); // R2
    end
  end
endmodule

// File: rtl/shexp_decoder.sv
module shexp_decoder
  import shexp_pkg::*;
#(
  parameter int MANT_W      = 9,
  parameter int EXP_W       = 5,
  parameter int EXP_BIAS    = 15,
  parameter int SYNC_STAGES = 2,
  localparam int N_CH       = 3,
  localparam int WORD_W     = N_CH * MANT_W + EXP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [31:0]       out_red,
  output logic [31:0]       out_green,
  output logic [31:0]       out_blue,
  output logic [31:0]       out_alpha
);
  logic  rst_sync_n;
  logic  take;
  fp32_t conv_res [N_CH];
  fp32_t chan_q   [N_CH];
  fp32_t chan_d   [N_CH];
  fp32_t alpha_q, alpha_d;
  logic  valid_q, valid_d;

  shexp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign in_ready = rst_sync_n;
  assign take     = in_valid & in_ready;

  // one converter per colour channel, all sharing the exponent field
  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    shexp_chan_conv #(
      .MANT_W   (MANT_W),
      .EXP_W    (EXP_W),
      .EXP_BIAS (EXP_BIAS)
    ) u_conv (
      .mant   (in_word[c*MANT_W +: MANT_W]),
      .sh_exp (in_word[WORD_W-1 -: EXP_W]),
      .fp     (conv_res[c])
    );
  end

  // next state
  always_comb begin
    valid_d = take;
    alpha_d = take ? FP_ONE : alpha_q;
    for (int c = 0; c < N_CH; c++) begin
      chan_d[c] = take ? conv_res[c] : chan_q[c];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      alpha_q <= '0;
      for (int c = 0; c < N_CH; c++) begin
        chan_q[c] <= '0;
      end
    end else begin
      valid_q <= valid_d;
      alpha_q <= alpha_d;
      for (int c = 0; c < N_CH; c++) begin
        chan_q[c] <= chan_d[c];
      end
    end
  end

  assign out_valid = valid_q;
  assign out_red   = chan_q[0];
  assign out_green = chan_q[1];
  assign out_blue  = chan_q[2];
  assign out_alpha = alpha_q;

  AST_ACCEPT_TO_VALID : assert property (@(posedge clk) disable iff (!rst_sync_n)
    take |=> out_valid); // R5
  AST_IDLE_NO_VALID : assert property (@(posedge clk) disable iff (!rst_sync_n)
    !take |=> !out_valid); // R5
  AST_HOLD_OUTPUTS : assert property (@(posedge clk) disable iff (!rst_sync_n)
    !take |=> ($stable(out_red) && $stable(out_green) && $stable(out_blue) && $stable(out_alpha))); // R7
  AST_ZERO_RED : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && in_word[MANT_W-1:0] == '0) |=> (out_red == '0)); // R3
  AST_ALPHA_ONE : assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (out_alpha == FP_ONE)); // R4
  AST_NORMAL_RED : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_red != '0) |-> (!out_red[31] && out_red[30:23] != 8'h00 && out_red[30:23] != 8'hFF)); // R8
endmodule

// File: tb/shexp_decoder_tb.sv
`timescale 1ns/1ps
module shexp_decoder_tb;
  localparam int N_VEC = 6;
  localparam logic [127:0] VECS [N_VEC] = '{
    {32'h7C000401, 32'h3B000000, 32'h3B800000, 32'h3F000000},
    {32'hC7FC0003, 32'h40400000, 32'h00000000, 32'h43FF8000},
    {32'h0003FE01, 32'h33800000, 32'h37FF8000, 32'h00000000},
    {32'hF81601FF, 32'h477F8000, 32'h47000000, 32'h44200000},
    {32'hF8000000, 32'h00000000, 32'h00000000, 32'h00000000},
    {32'hA01D5555, 32'h41AA8000, 32'h412A0000, 32'h3EE00000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_valid;
  logic [31:0] out_red, out_green, out_blue, out_alpha;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shexp_decoder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_red   (out_red),
    .out_green (out_green),
    .out_blue  (out_blue),
    .out_alpha (out_alpha)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] ref_fp(input int m, input int e);
    real v;
    logic [63:0] d;
    if (m == 0) return 32'h0;
    v = real'(m) * (2.0 ** (e - 24));
    d = $realtobits(v);
    return {1'b0, 8'(d[62:52] - 11'd896), d[51:29]};
  endfunction

  function automatic logic [31:0] sweep_word(input int e);
    int r, g, b;
    r = (e * 37 + 1) % 512;
    g = (e * 101) % 512;
    b = 1 << (e % 9);
    return {5'(e), 9'(b), 9'(g), 9'(r)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_red;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    repeat (3) @(negedge clk);
    check("R6 valid in reset", 32'(out_valid), 32'd0);
    check("R6 ready in reset", 32'(in_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 ready after one edge", 32'(in_ready), 32'd0);
    @(negedge clk);
    check("R6 ready after two edges", 32'(in_ready), 32'd1);
    check("R5 idle valid", 32'(out_valid), 32'd0);

    // table of hand-derived vectors, one word then one idle cycle
    for (int i = 0; i < N_VEC; i++) begin
      in_valid = 1'b1;
      in_word  = VECS[i][127:96];
      @(negedge clk);
      in_valid = 1'b0;
      check("R5 valid after accept", 32'(out_valid), 32'd1);
      check("R1 R2 R3 R8 red",   out_red,   VECS[i][95:64]);
      check("R1 R2 R3 R8 green", out_green, VECS[i][63:32]);
      check("R1 R2 R3 R8 blue",  out_blue,  VECS[i][31:0]);
      check("R4 alpha", out_alpha, 32'h3F800000);
      @(negedge clk);
      check("R5 valid drops", 32'(out_valid), 32'd0);
    end

    // R7: garbage on the word without valid leaves outputs untouched
    last_red = out_red;
    in_word  = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    check("R7 red held", out_red, last_red);
    check("R7 blue held", out_blue, 32'h3EE00000);
    check("R7 valid low", 32'(out_valid), 32'd0);

    // back-to-back stream across every exponent value
    in_valid = 1'b1;
    for (int e = 0; e < 32; e++) begin
      logic [31:0] w;
      w = sweep_word(e);
      in_word = w;
      @(negedge clk);
      check("R5 stream valid", 32'(out_valid), 32'd1);
      check("R2 stream red",   out_red,   ref_fp(int'(w[8:0]),   e));
      check("R2 stream green", out_green, ref_fp(int'(w[17:9]),  e));
      check("R2 stream blue",  out_blue,  ref_fp(int'(w[26:18]), e));
    end

    // R6: reset during a stream, word held valid throughout
    in_word = 32'hF81601FF;
    #2 rst_n = 1'b0;
    #1;
    check("R6 async clear valid", 32'(out_valid), 32'd0);
    check("R6 ready low in reset", 32'(in_ready), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 no output before ready", 32'(out_valid), 32'd0);
    check("R6 ready low one edge", 32'(in_ready), 32'd0);
    @(negedge clk);
    check("R6 ready high two edges", 32'(in_ready), 32'd1);
    check("R6 still no output", 32'(out_valid), 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 first word valid", 32'(out_valid), 32'd1);
    check("R8 max red", out_red, 32'h477F8000);
    check("R4 alpha after reset", out_alpha, 32'h3F800000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule